// File: doc/BRIEF.md
# Privileged Operation Permission Checker

This combinational block decides, for a privileged operation about to execute, whether the core may proceed or must trap, and with which kind of trap. The operations it judges are wait-for-interrupt, the supervisor address-translation fence, the two hypervisor fences (guest-virtual and guest-physical), and the three hypervisor memory operations (load, store and execute-load). It reads the current privilege, the virtualization mode, the trap-wait and trap-translation controls of the machine status, the guest-fence trap and user-hypervisor-access controls of the hypervisor status, and whether the hypervisor extension is present.

The answer is a 2-bit verdict, the matching exception cause, a halt request for an accepted wait-for-interrupt and a hypervisor-access qualifier for an accepted hypervisor memory operation. The surrounding pipeline uses the qualifier to pick the guest translation regime for the access; performing the fence, halting the core and the access itself happen elsewhere. No clock is involved: outputs follow the inputs in the same cycle.

Top module: `priv_chk`

## Requirements
- R1: The verdict is 2'b00 allow, 2'b01 illegal instruction, 2'b10 virtual instruction fault, and is never 2'b11; the cause output is 0 for allow, 2 for illegal and 22 for virtual. Operation codes: 0 wait-for-interrupt, 1 supervisor fence, 2 guest-virtual fence, 3 guest-physical fence, 4 hypervisor load, 5 hypervisor store, 6 hypervisor execute-load, 7 reserved. Privilege codes: 0 user, 1 supervisor, 3 machine; code 2 is treated as user.
- R2: Wait-for-interrupt gives a virtual fault when virtualization is on, or in supervisor with trap-wait set; in every other case it is allowed.
- R3: The supervisor fence is illegal in user privilege, and in supervisor privilege with trap-translation set.
- R4: A supervisor fence not made illegal by R3 gives a virtual fault when the hypervisor extension is present, virtualization is on and the guest-fence trap is set; otherwise it is allowed.
- R5: The guest-virtual fence gives a virtual fault in virtualized supervisor, is allowed in machine privilege and in non-virtualized supervisor, and is illegal in every other case.
- R6: The guest-physical fence is illegal in non-virtualized supervisor with trap-translation set; otherwise it follows R5.
- R7: Hypervisor load, store and execute-load pass the privilege check in machine privilege, in non-virtualized supervisor, and in non-virtualized user with user-hypervisor-access set. Load and store accept every size code (0 byte, 1 halfword, 2 word, 3 doubleword) and either signedness.
- R8: A hypervisor memory operation failing R7 gives a virtual fault when virtualization is on, else an illegal instruction.
- R9: An execute-load that passes R7 is allowed only for unsigned halfword or unsigned word (size 1 or 2 with the signed input low); any other size is illegal. When R7 fails, R8 decides, whatever the size.
- R10: The hypervisor-access qualifier is high exactly when a hypervisor load, store or execute-load is allowed.
- R11: The halt request is high exactly when wait-for-interrupt is allowed.
- R12: The reserved operation code 7 is always illegal and raises neither halt request nor qualifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (R1) |
| priv_i | input | 2 | Current privilege (R1) |
| virt_i | input | 1 | Virtualization mode on |
| tw_i | input | 1 | Machine status trap-wait control |
| tvm_i | input | 1 | Machine status trap-translation control |
| vtvm_i | input | 1 | Hypervisor status guest-fence trap control |
| hu_i | input | 1 | Hypervisor status user-hypervisor-access control |
| hext_i | input | 1 | Hypervisor extension present |
| size_i | input | 2 | Access size code of a hypervisor memory operation |
| sgn_i | input | 1 | Signed access of a hypervisor memory operation |
| verdict_o | output | 2 | Verdict code |
| cause_o | output | 5 | Exception cause, 0 when allowed |
| halt_req_o | output | 1 | Accepted wait-for-interrupt |
| hyp_access_o | output | 1 | Accepted hypervisor memory operation |

## Verification
The privilege rejection of R8 and the size check of R9 can both apply to the same execute-load, and the trap-translation rule of R6 overlaps the virtualization rule of R5 for the guest-physical fence. An exhaustive sweep of all operation, privilege, control and size combinations provokes both overlaps, and a scoreboard compares verdict, cause, halt and qualifier against a priority model in which the privilege check of R7/R8 outranks the size check and the trap-translation illegal outranks the fence rules. Directed vectors name each overlap explicitly, such as a signed byte execute-load in virtualized user, which must give a virtual fault rather than an illegal instruction.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;

  typedef enum logic [2:0] {
    OP_WFI    = 3'd0,
    OP_SFENCE = 3'd1,
    OP_HFV    = 3'd2,
    OP_HFG    = 3'd3,
    OP_HLD    = 3'd4,
    OP_HST    = 3'd5,
    OP_HLX    = 3'd6,
    OP_RSV    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    VD_ALLOW = 2'b00,
    VD_ILL   = 2'b01,
    VD_VIRT  = 2'b10
  } verdict_e;

  localparam logic [1:0] MODE_U = 2'd0;
  localparam logic [1:0] MODE_S = 2'd1;
  localparam logic [1:0] MODE_M = 2'd3;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;
  localparam logic [1:0] SZ_D = 2'd3;

  typedef struct packed {
    logic is_m;
    logic is_s;
    logic is_u;
    logic virt;
  } ctx_t;

endpackage

// File: rtl/priv_chk_ctx.sv
module priv_chk_ctx
  import priv_chk_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  output ctx_t       ctx_o
);

  always_comb begin
    ctx_o.is_m = (priv_i == MODE_M);
    ctx_o.is_s = (priv_i == MODE_S);
    // reserved code 2 collapses to user
    ctx_o.is_u = !((priv_i == MODE_M) || (priv_i == MODE_S));
    ctx_o.virt = virt_i;
  end

endmodule

// File: rtl/priv_chk_fence.sv
module priv_chk_fence
  import priv_chk_pkg::*;
(
  input  op_e      op_i,
  input  ctx_t     ctx_i,
  input  logic     tw_i,
  input  logic     tvm_i,
  input  logic     vtvm_i,
  input  logic     hext_i,
  output verdict_e vd_o,
  output logic     halt_o
);

  logic hs_mode;
  logic vs_mode;

  assign hs_mode = ctx_i.is_s && !ctx_i.virt;
  assign vs_mode = ctx_i.is_s && ctx_i.virt;

  always_comb begin
    vd_o   = VD_ALLOW;
    halt_o = 1'b0;
    case (op_i)
      OP_WFI: begin
        if ((ctx_i.is_s && tw_i) || ctx_i.virt) vd_o = VD_VIRT;
        else halt_o = 1'b1;
      end
      OP_SFENCE: begin
        if (ctx_i.is_u || (ctx_i.is_s && tvm_i)) vd_o = VD_ILL;
        else if (hext_i && ctx_i.virt && vtvm_i) vd_o = VD_VIRT;
      end
      OP_HFV, OP_HFG: begin
        // trap-translation outranks the common fence rules
        if (op_i == OP_HFG && hs_mode && tvm_i) vd_o = VD_ILL;
        else if (vs_mode) vd_o = VD_VIRT;
        else if (!(ctx_i.is_m || hs_mode)) vd_o = VD_ILL;
      end
      default: vd_o = VD_ILL;
    endcase
  end

endmodule

// File: rtl/priv_chk_hmem.sv
module priv_chk_hmem
  import priv_chk_pkg::*;
#(
  parameter bit STRICT_XSIZE = 1'b1
) (
  input  op_e        op_i,
  input  ctx_t       ctx_i,
  input  logic       hu_i,
  input  logic [1:0] size_i,
  input  logic       sgn_i,
  output verdict_e   vd_o,
  output logic       hacc_o
);

  logic priv_ok;
  logic xsize_ok;
  logic is_mem;

  assign is_mem  = (op_i == OP_HLD) || (op_i == OP_HST) || (op_i == OP_HLX);
  assign priv_ok = ctx_i.is_m
                || (ctx_i.is_s && !ctx_i.virt)
                || (ctx_i.is_u && !ctx_i.virt && hu_i);

  generate
    if (STRICT_XSIZE) begin : g_xsize_strict
      assign xsize_ok = !sgn_i && ((size_i == SZ_H) || (size_i == SZ_W));
    end else begin : g_xsize_any
      assign xsize_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    vd_o   = VD_ALLOW;
    hacc_o = 1'b0;
    if (!is_mem) begin
      vd_o = VD_ILL;
    end else if (!priv_ok) begin
      vd_o = ctx_i.virt ? VD_VIRT : VD_ILL;
    end else if (op_i == OP_HLX && !xsize_ok) begin
      vd_o = VD_ILL;
    end else begin
      hacc_o = 1'b1;
    end
  end

endmodule

// File: rtl/priv_chk.sv
module priv_chk
  import priv_chk_pkg::*;
#(
  parameter int unsigned CAUSE_W    = 5,
  parameter int unsigned ILL_CAUSE  = 2,
  parameter int unsigned VIRT_CAUSE = 22
) (
  input  logic [2:0]         op_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               tw_i,
  input  logic               tvm_i,
  input  logic               vtvm_i,
  input  logic               hu_i,
  input  logic               hext_i,
  input  logic [1:0]         size_i,
  input  logic               sgn_i,
  output logic [1:0]         verdict_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               halt_req_o,
  output logic               hyp_access_o
);

  localparam logic [CAUSE_W-1:0] ILL_C  = CAUSE_W'(ILL_CAUSE);
  localparam logic [CAUSE_W-1:0] VIRT_C = CAUSE_W'(VIRT_CAUSE);

  op_e      op;
  ctx_t     ctx;
  verdict_e fence_vd;
  verdict_e hmem_vd;
  verdict_e vd;
  logic     fence_halt;
  logic     hmem_hacc;

  assign op = op_e'(op_i);

  priv_chk_ctx u_ctx (
    .priv_i (priv_i),
    .virt_i (virt_i),
    .ctx_o  (ctx)
  );

  priv_chk_fence u_fence (
    .op_i   (op),
    .ctx_i  (ctx),
    .tw_i   (tw_i),
    .tvm_i  (tvm_i),
    .vtvm_i (vtvm_i),
    .hext_i (hext_i),
    .vd_o   (fence_vd),
    .halt_o (fence_halt)
  );

  priv_chk_hmem #(.STRICT_XSIZE(1'b1)) u_hmem (
    .op_i   (op),
    .ctx_i  (ctx),
    .hu_i   (hu_i),
    .size_i (size_i),
    .sgn_i  (sgn_i),
    .vd_o   (hmem_vd),
    .hacc_o (hmem_hacc)
  );

  always_comb begin
    if (op == OP_RSV)  vd = VD_ILL;
    else if (op_i[2])  vd = hmem_vd;
    else               vd = fence_vd;
  end

  always_comb begin
    case (vd)
      VD_ILL:  cause_o = ILL_C;
      VD_VIRT: cause_o = VIRT_C;
      default: cause_o = '0;
    endcase
  end

  assign verdict_o    = vd;
  assign halt_req_o   = !op_i[2] && fence_halt;
  assign hyp_access_o = op_i[2] && (op != OP_RSV) && hmem_hacc;

endmodule

// File: rtl/priv_chk_sva.sv
module priv_chk_sva #(
  parameter int unsigned CAUSE_W    = 5,
  parameter int unsigned ILL_CAUSE  = 2,
  parameter int unsigned VIRT_CAUSE = 22
) (
  input logic [2:0]         op_i,
  input logic [1:0]         priv_i,
  input logic               virt_i,
  input logic               sgn_i,
  input logic [1:0]         verdict_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               halt_req_o,
  input logic               hyp_access_o
);

  logic known;
  assign known = !$isunknown({op_i, priv_i, virt_i, sgn_i});

  always_comb begin
    if (known) begin
      a_r1_verdict_code: assert (verdict_o != 2'b11)
        else $error("verdict code 11 produced");
      a_r1_cause_match: assert ((verdict_o == 2'b00 && cause_o == '0)
                             || (verdict_o == 2'b01 && cause_o == CAUSE_W'(ILL_CAUSE))
                             || (verdict_o == 2'b10 && cause_o == CAUSE_W'(VIRT_CAUSE)))
        else $error("cause does not match verdict");
      a_r2_wfi_virt: assert (!(op_i == 3'd0 && virt_i) || verdict_o == 2'b10)
        else $error("virtualized wait-for-interrupt not faulted");
      a_r5_hfence_m_allow: assert (!((op_i == 3'd2 || op_i == 3'd3) && priv_i == 2'd3)
                                   || verdict_o == 2'b00)
        else $error("machine hypervisor fence not allowed");
      a_r9_hlx_unsigned: assert (!(op_i == 3'd6 && verdict_o == 2'b00) || !sgn_i)
        else $error("signed execute-load allowed");
      a_r10_hacc: assert (!hyp_access_o
                          || (verdict_o == 2'b00 && op_i >= 3'd4 && op_i <= 3'd6))
        else $error("qualifier without accepted memory operation");
      a_r11_halt: assert (!halt_req_o || (op_i == 3'd0 && verdict_o == 2'b00))
        else $error("halt without accepted wait-for-interrupt");
      a_r12_rsv: assert (op_i != 3'd7 || (verdict_o == 2'b01 && !halt_req_o && !hyp_access_o))
        else $error("reserved code not illegal");
    end
  end

endmodule

bind priv_chk priv_chk_sva #(
  .CAUSE_W    (CAUSE_W),
  .ILL_CAUSE  (ILL_CAUSE),
  .VIRT_CAUSE (VIRT_CAUSE)
) u_sva (
  .op_i         (op_i),
  .priv_i       (priv_i),
  .virt_i       (virt_i),
  .sgn_i        (sgn_i),
  .verdict_o    (verdict_o),
  .cause_o      (cause_o),
  .halt_req_o   (halt_req_o),
  .hyp_access_o (hyp_access_o)
);

// File: tb/tb_priv_chk.sv
module tb_priv_chk;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] op_i = '0;
  logic [1:0] priv_i = '0;
  logic virt_i = 0, tw_i = 0, tvm_i = 0, vtvm_i = 0, hu_i = 0, hext_i = 0;
  logic [1:0] size_i = '0;
  logic sgn_i = 0;
  logic [1:0] verdict_o;
  logic [4:0] cause_o;
  logic halt_req_o, hyp_access_o;

  priv_chk dut (
    .op_i(op_i), .priv_i(priv_i), .virt_i(virt_i), .tw_i(tw_i), .tvm_i(tvm_i),
    .vtvm_i(vtvm_i), .hu_i(hu_i), .hext_i(hext_i), .size_i(size_i), .sgn_i(sgn_i),
    .verdict_o(verdict_o), .cause_o(cause_o), .halt_req_o(halt_req_o),
    .hyp_access_o(hyp_access_o)
  );

  // expected: {verdict[1:0], cause[4:0], halt, hacc}
  logic [8:0] exp_q[$];
  string      tag_q[$];
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  function automatic logic [8:0] model(input logic [2:0] op, input logic [1:0] pv,
      input logic v, input logic tw, input logic tvm, input logic vtvm,
      input logic hu, input logic hx, input logic [1:0] sz, input logic sg);
    logic m, s, u, ok;
    logic [1:0] vd;
    logic h, ha;
    logic [4:0] c;
    m = (pv == 2'd3); s = (pv == 2'd1); u = !m && !s;
    vd = 2'b00; h = 0; ha = 0;
    if (op == 3'd0) begin
      if (v || (s && tw)) vd = 2'b10; else h = 1;
    end else if (op == 3'd1) begin
      if (u) vd = 2'b01;
      else if (s && tvm) vd = 2'b01;
      else if (hx && v && vtvm) vd = 2'b10;
    end else if (op == 3'd2 || op == 3'd3) begin
      if (op == 3'd3 && s && !v && tvm) vd = 2'b01;
      else if (s && v) vd = 2'b10;
      else if (!(m || (s && !v))) vd = 2'b01;
    end else if (op == 3'd7) begin
      vd = 2'b01;
    end else begin
      ok = m || (s && !v) || (u && !v && hu);
      if (!ok) vd = v ? 2'b10 : 2'b01;
      else if (op == 3'd6 && !(!sg && (sz == 2'd1 || sz == 2'd2))) vd = 2'b01;
      else ha = 1;
    end
    c = (vd == 2'b01) ? 5'd2 : (vd == 2'b10) ? 5'd22 : 5'd0;
    return {vd, c, h, ha};
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R2/R11";
      3'd1: return "R3/R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4, 3'd5: return "R7/R8/R10";
      3'd6: return "R9/R10";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [1:0] pv, input logic v,
      input logic tw, input logic tvm, input logic vtvm, input logic hu,
      input logic hx, input logic [1:0] sz, input logic sg, input string tag);
    @(posedge clk);
    #1;
    op_i = op; priv_i = pv; virt_i = v; tw_i = tw; tvm_i = tvm; vtvm_i = vtvm;
    hu_i = hu; hext_i = hx; size_i = sz; sgn_i = sg;
    exp_q.push_back(model(op, pv, v, tw, tvm, vtvm, hu, hx, sz, sg));
    tag_q.push_back(tag);
  endtask

  // monitor: sample mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if ({verdict_o, cause_o, halt_req_o, hyp_access_o} !== e ||
          verdict_o == 2'b11) begin
        fails++;
        $display("FAIL %s R1 op=%0d priv=%0d v=%0b: got vd=%b cause=%0d halt=%b hacc=%b exp vd=%b cause=%0d halt=%b hacc=%b",
                 t, op_i, priv_i, virt_i, verdict_o, cause_o, halt_req_o, hyp_access_o,
                 e[8:7], e[6:2], e[1], e[0]);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle inputs after reset: user wait-for-interrupt allowed (R1, R2, R11)
    apply(3'd0, 2'd0, 0, 0, 0, 0, 0, 0, 2'd0, 0, "R1 reset");
    // directed corners
    apply(3'd0, 2'd1, 0, 1, 0, 0, 0, 0, 2'd0, 0, "R2 S+trap-wait");
    apply(3'd0, 2'd3, 1, 0, 0, 0, 0, 0, 2'd0, 0, "R2 virt");
    apply(3'd0, 2'd3, 0, 1, 0, 0, 0, 0, 2'd0, 0, "R11 M halt");
    apply(3'd1, 2'd0, 0, 0, 0, 0, 0, 1, 2'd0, 0, "R3 user");
    apply(3'd1, 2'd1, 1, 0, 1, 1, 0, 1, 2'd0, 0, "R3 tvm outranks R4");
    apply(3'd1, 2'd1, 1, 0, 0, 1, 0, 1, 2'd0, 0, "R4 vtvm");
    apply(3'd1, 2'd1, 1, 0, 0, 1, 0, 0, 2'd0, 0, "R4 no hext");
    apply(3'd2, 2'd1, 1, 0, 0, 0, 0, 1, 2'd0, 0, "R5 vs");
    apply(3'd2, 2'd0, 0, 0, 0, 0, 0, 1, 2'd0, 0, "R5 user");
    apply(3'd3, 2'd1, 0, 0, 1, 0, 0, 1, 2'd0, 0, "R6 hs tvm");
    apply(3'd3, 2'd1, 1, 0, 1, 0, 0, 1, 2'd0, 0, "R6 vs tvm");
    apply(3'd4, 2'd0, 0, 0, 0, 0, 1, 0, 2'd3, 1, "R7 user hu");
    apply(3'd5, 2'd0, 0, 0, 0, 0, 0, 0, 2'd0, 0, "R8 user no hu");
    apply(3'd5, 2'd1, 1, 0, 0, 0, 1, 0, 2'd2, 0, "R8 vs");
    apply(3'd6, 2'd0, 1, 0, 0, 0, 1, 0, 2'd0, 1, "R9 reject outranks size");
    apply(3'd6, 2'd3, 0, 0, 0, 0, 0, 0, 2'd1, 1, "R9 signed half");
    apply(3'd6, 2'd3, 0, 0, 0, 0, 0, 0, 2'd2, 0, "R9 unsigned word");
    apply(3'd6, 2'd1, 0, 0, 0, 0, 0, 0, 2'd3, 0, "R9 double");
    apply(3'd4, 2'd2, 0, 0, 0, 0, 1, 0, 2'd0, 0, "R10 reserved priv as user");
    apply(3'd7, 2'd3, 0, 0, 0, 0, 1, 1, 2'd1, 0, "R12 reserved op");
    // exhaustive sweep
    for (int k = 0; k < 16384; k++) begin
      logic [13:0] b;
      b = 14'(k);
      apply(b[2:0], b[4:3], b[5], b[6], b[7], b[8], b[9], b[10], b[12:11], b[13],
            op_tag(b[2:0]));
    end
    @(posedge clk);
    wait (exp_q.size() == 0);
    @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule